// File: doc/BRIEF.md
# ARINC 429 Word Receiver with Label Acceptance

This block sits behind an external line receiver that turns the differential ARINC 429 pair into two logic signals: one active while the line is High, one active while it is Low. Both are synchronised and debounced. A bit is taken each time the filtered line leaves Null for High (a one) or Low (a zero). Runs of Null mark the end of a word and the gap that must come before the next one. The bit period follows a per-channel rate select and a clock-frequency parameter.

Each complete 32-bit word is checked for odd parity. Its 8-bit label then indexes a host-written acceptance table. Words whose label is enabled go into a first-word-fall-through buffer, with their parity error flag stored alongside. A host register port reads the head word and the status. It also sets an interrupt threshold and clears the sticky error flags. The interrupt stays high while the buffer holds at least the threshold number of words.

Top module: `a429_rx`

## Requirements
- R1: The line inputs pass through a two-flop synchroniser and a filter that changes the line state only after FILT equal consecutive samples. The pair (hi=1, lo=0) is High, (hi=0, lo=1) is Low, and both equal is Null. A pulse shorter than FILT samples, and a stretch with both inputs high, act as Null and do not disturb a following word.
- R2: rate_sel picks the bit period: 0 is CLK_KHZ/100 cycles (100 kbps), 1 is CLK_KHZ/50 cycles (50 kbps), 2 and 3 are CLK_KHZ*2/25 cycles (12.5 kbps). Words are decoded correctly at every rate.
- R3: A word ends when the line has been Null for two bit periods. The first bit received becomes word bit 0, and the label is word bits [7:0].
- R4: A word is valid only if the line was Null for at least three bit periods before its first bit. Otherwise the word is discarded and the framing error flag is set.
- R5: A word that ends with fewer or more than 32 bits is discarded and sets the framing error flag (status bit 3). The flag is sticky until the host writes 1 to bit 1 at address 1.
- R6: Odd parity is checked over all 32 bits. A word with even parity is still stored, with its error flag set, and that flag reads as status bit 4 while the word is at the head of the buffer.
- R7: Address 256+L holds the enable bit of label L in data bit 0; it is writable, it reads back, and it resets to 0. A valid word whose label is disabled is dropped and leaves the buffer level unchanged.
- R8: The buffer is first-in first-out. A read of address 0 returns the head word. Asserting bus_rd at address 0 removes the head word, and doing so on an empty buffer has no effect.
- R9: Status at address 1 gives empty in bit 0, full in bit 1 and the fill level in bits [31:16]. After reset it shows empty with level 0.
- R10: A valid, enabled word that arrives while the buffer is full is lost and sets the overflow flag (status bit 2). The flag is sticky until the host writes 1 to bit 0 at address 1.
- R11: Address 2 holds the interrupt threshold in bits [6:0], reset value 1. irq is high while the level is at least the threshold, and a threshold of 0 keeps irq low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, CLK_KHZ kHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_hi | input | 1 | Line receiver output, high while the line is High |
| rx_lo | input | 1 | Line receiver output, high while the line is Low |
| rate_sel | input | 2 | Bit rate select |
| bus_addr | input | 9 | Host register address |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe; at address 0 it removes the head word |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Host read data, combinational from bus_addr |
| irq | output | 1 | Buffer level interrupt |

## Verification
The bench builds the receiver with CLK_KHZ=1000, DEPTH=8 and FILT=2. At that clock the three bit periods are 10, 20 and 80 cycles, so words at the slowest rate still fit in a short run, and a two-sample filter lets one-cycle glitches be tried directly. An eight-entry buffer makes full, overflow and its sticky clear reachable with nine words. Random words spread over a randomly written label table exercise parity and acceptance across the full 8-bit label space.

// File: rtl/a429_rx.sv
module a429_rx #(
  parameter int CLK_KHZ = 1000,
  parameter int DEPTH   = 64,
  parameter int FILT    = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_hi,
  input  logic        rx_lo,
  input  logic [1:0]  rate_sel,
  input  logic [8:0]  bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq
);
  localparam int AW       = $clog2(DEPTH);
  localparam int LW       = $clog2(DEPTH + 1);
  localparam int PER_FAST = CLK_KHZ / 100;
  localparam int PER_MID  = CLK_KHZ / 50;
  localparam int PER_SLOW = CLK_KHZ * 2 / 25;
  localparam int CW       = $clog2(3 * PER_SLOW + 1);
  localparam int FW       = $clog2(FILT + 1);

  logic [1:0]    hi_s, lo_s, cand, lvl, lvl_q;
  logic [FW-1:0] run;
  logic [CW-1:0] nrun, per;
  logic          armed, pre_gap, frm, ovf;
  logic [5:0]    bcnt;
  logic [31:0]   sh;
  logic [255:0]  lbl_en;
  logic [6:0]    thresh;
  logic [AW-1:0] wp, rp;
  logic [LW-1:0] level;
  logic [32:0]   mem [DEPTH];

  always_comb begin
    case (rate_sel)
      2'd0:    per = CW'(PER_FAST);
      2'd1:    per = CW'(PER_MID);
      default: per = CW'(PER_SLOW);
    endcase
  end

  wire [CW-1:0] end_lim = per + per;
  wire [CW-1:0] gap_lim = per + per + per;
  wire [1:0]    sym     = (hi_s[1] ^ lo_s[1]) ? {hi_s[1], lo_s[1]} : 2'b00;
  wire          is_null = (lvl == 2'b00);
  wire          bit_evt = (lvl != lvl_q) && !is_null;
  wire          end_evt = is_null && (bcnt != 6'd0) && (nrun >= end_lim - 1'b1);
  wire          word_ok = (bcnt == 6'd32) && pre_gap;
  wire          take    = end_evt && word_ok && lbl_en[sh[7:0]];

  wire          empty   = (level == '0);
  wire          full    = (level == LW'(DEPTH));
  wire          rd0     = bus_rd && (bus_addr == 9'd0);
  wire          pop     = rd0 && !empty;
  wire          push_ok = take && (!full || pop);
  wire          clr_ovf = bus_wr && (bus_addr == 9'd1) && bus_wdata[0];
  wire          clr_frm = bus_wr && (bus_addr == 9'd1) && bus_wdata[1];
  wire          unused_wd = &{1'b0, bus_wdata[31:7]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_s <= '0; lo_s <= '0; cand <= '0; run <= '0;
      lvl <= '0; lvl_q <= '0; nrun <= '0; armed <= 1'b0;
      pre_gap <= 1'b0; bcnt <= '0; sh <= '0; frm <= 1'b0;
    end else begin
      hi_s  <= {hi_s[0], rx_hi};
      lo_s  <= {lo_s[0], rx_lo};
      lvl_q <= lvl;
      if (sym != cand) begin
        cand <= sym;
        run  <= FW'(1);
      end else if (run < FW'(FILT)) begin
        run <= run + 1'b1;
      end
      if (run == FW'(FILT)) lvl <= cand;

      if (!is_null) nrun <= '0;
      else if (nrun < gap_lim) nrun <= nrun + 1'b1;

      if (bit_evt) armed <= 1'b0;
      else if (is_null && nrun >= gap_lim - 1'b1) armed <= 1'b1;

      if (clr_frm) frm <= 1'b0;
      if (end_evt) begin
        bcnt <= '0;
        if (!word_ok) frm <= 1'b1;
      end else if (bit_evt) begin
        sh <= {lvl[1], sh[31:1]};
        if (bcnt != 6'd33) bcnt <= bcnt + 1'b1;
        if (bcnt == 6'd0) pre_gap <= armed;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; level <= '0; ovf <= 1'b0;
      thresh <= 7'd1; lbl_en <= '0;
    end else begin
      if (push_ok) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)     rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      if (push_ok && !pop)      level <= level + 1'b1;
      else if (pop && !push_ok) level <= level - 1'b1;
      if (clr_ovf) ovf <= 1'b0;
      if (take && full && !pop) ovf <= 1'b1;
      if (bus_wr && bus_addr[8]) lbl_en[bus_addr[7:0]] <= bus_wdata[0];
      if (bus_wr && bus_addr == 9'd2) thresh <= bus_wdata[6:0];
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= {~^sh, sh};
  end

  wire head_perr = !empty && mem[rp][32];

  always_comb begin
    if (bus_addr[8])
      bus_rdata = {31'd0, lbl_en[bus_addr[7:0]]};
    else begin
      case (bus_addr[7:0])
        8'd0:    bus_rdata = empty ? 32'd0 : mem[rp][31:0];
        8'd1:    bus_rdata = {16'(level), 11'd0, head_perr, frm, ovf, full, empty};
        8'd2:    bus_rdata = {25'd0, thresh};
        default: bus_rdata = {31'd0, unused_wd};
      endcase
    end
  end

  assign irq = (thresh != 7'd0) && ({25'd0, thresh} <= 32'(level));
endmodule

// File: rtl/a429_rx_chk.sv
module a429_rx_chk #(
  parameter int DEPTH = 64,
  parameter int LW    = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic [LW-1:0] level,
  input logic          full,
  input logic          empty,
  input logic          ovf,
  input logic          frm,
  input logic          irq,
  input logic          push_ok,
  input logic          rd0,
  input logic          clr_ovf,
  input logic          clr_frm,
  input logic [5:0]    bcnt
);
  // R9
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(level) <= DEPTH);
  // R9
  full_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !empty);
  // R8
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd0 && empty && !push_ok) |=> $stable(level));
  // R10
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !clr_ovf) |=> ovf);
  // R5
  frm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm && !clr_frm) |=> frm);
  // R11
  irq_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !empty);
  // R5
  bit_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bcnt <= 6'd33);
endmodule

bind a429_rx a429_rx_chk #(.DEPTH(DEPTH), .LW(LW)) chk_i (
  .clk(clk), .rst_n(rst_n), .level(level), .full(full), .empty(empty),
  .ovf(ovf), .frm(frm), .irq(irq), .push_ok(push_ok), .rd0(rd0),
  .clr_ovf(clr_ovf), .clr_frm(clr_frm), .bcnt(bcnt)
);

// File: tb/a429_rx_test.sv
module a429_rx_test;
  localparam int CLK_PER = 10;
  localparam int DEPTH   = 8;

  logic        clk = 1'b0, rst_n = 1'b0, rx_hi = 1'b0, rx_lo = 1'b0;
  logic [1:0]  rate_sel = 2'd0;
  logic [8:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  a429_rx #(.CLK_KHZ(1000), .DEPTH(DEPTH), .FILT(2)) uut (
    .clk(clk), .rst_n(rst_n), .rx_hi(rx_hi), .rx_lo(rx_lo), .rate_sel(rate_sel),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  always #(CLK_PER / 2) clk = ~clk;

  int          errs = 0, checks = 0;
  bit          lbl_tab [256];
  logic [32:0] expq [$];
  logic [31:0] st, rv;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int per_of(input logic [1:0] rs);
    return (rs == 2'd0) ? 10 : (rs == 2'd1) ? 20 : 80;
  endfunction

  function automatic logic [32:0] entry_of(input logic [31:0] w);
    return {~^w, w};
  endfunction

  task automatic idle(input int n);
    rx_hi = 1'b0; rx_lo = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input bit b, input int per);
    rx_hi = b; rx_lo = !b;
    repeat (per / 2) @(negedge clk);
    rx_hi = 1'b0; rx_lo = 1'b0;
    repeat (per - per / 2) @(negedge clk);
  endtask

  task automatic send_word(input logic [31:0] w, input int nbits);
    for (int i = 0; i < nbits; i++) send_bit(w[i % 32], per_of(rate_sel));
  endtask

  task automatic send_frame(input logic [31:0] w);
    send_word(w, 32);
    idle(5 * per_of(rate_sel));
  endtask

  task automatic bus_write(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic pop_one();
    @(negedge clk);
    bus_addr = 9'd0; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic drain(input string req);
    logic [32:0] e;
    while (expq.size() > 0) begin
      e = expq.pop_front();
      bus_read(9'd0, rv);
      bus_read(9'd1, st);
      chk(req, "head word", rv, e[31:0]);
      chk("R6", "head parity flag", st[4], e[32]);
      pop_one();
    end
    bus_read(9'd1, st);
    chk("R9", "empty after drain", st[1:0], 2'b01);
  endtask

  function automatic logic [31:0] with_label(input logic [7:0] l);
    return {$urandom(), l} >> 0;
  endfunction

  initial begin
    #(CLK_PER * 150000);
    errs++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [31:0] w;
    void'($urandom(32'h1A29));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    bus_read(9'd1, st);
    chk("R9", "reset status low bits", st[4:0], 5'b00001);
    chk("R9", "reset level", st[31:16], 0);
    chk("R11", "reset irq", irq, 0);
    bus_read(9'd2, rv);
    chk("R11", "reset threshold", rv, 1);
    bus_read(9'h1_11, rv);
    chk("R7", "reset label entry", rv, 0);

    for (int l = 0; l < 256; l++) begin
      lbl_tab[l] = ($urandom() % 2) == 1;
      bus_write(9'h100 | 9'(l), {31'd0, lbl_tab[l]});
    end
    lbl_tab[8'h11] = 1'b1; bus_write(9'h111, 32'd1);
    lbl_tab[8'h22] = 1'b0; bus_write(9'h122, 32'd0);
    bus_read(9'h111, rv); chk("R7", "label 11 readback", rv, 1);
    bus_read(9'h122, rv); chk("R7", "label 22 readback", rv, 0);
    bus_write(9'd2, 32'd0);
    idle(60);

    for (int b = 0; b < 5; b++) begin
      int n;
      n = 1 + int'($urandom() % DEPTH);
      for (int k = 0; k < n; k++) begin
        w = $urandom();
        send_frame(w);
        if (lbl_tab[w[7:0]]) expq.push_back(entry_of(w));
      end
      bus_read(9'd1, st);
      chk("R7", "level after random batch", st[31:16], expq.size());
      chk("R5", "no framing error on clean words", st[3], 0);
      drain("R3");
    end

    w = {24'hABCDEF, 8'h22};
    send_frame(w);
    bus_read(9'd1, st);
    chk("R7", "disabled label dropped", st[31:16], 0);

    w = {24'h000001, 8'h11};
    send_frame(w); expq.push_back(entry_of(w));
    w = {24'h000003, 8'h11};
    send_frame(w); expq.push_back(entry_of(w));
    drain("R6");

    for (int rs = 1; rs <= 2; rs++) begin
      rate_sel = 2'(rs);
      idle(5 * per_of(rate_sel));
      for (int k = 0; k < 2; k++) begin
        w = with_label(8'h11);
        send_frame(w); expq.push_back(entry_of(w));
      end
      bus_read(9'd1, st);
      chk("R2", "level at slower rate", st[31:16], 2);
      drain("R2");
    end
    rate_sel = 2'd0;
    idle(60);

    send_word(with_label(8'h11), 31);
    idle(50);
    bus_read(9'd1, st);
    chk("R5", "short word sets framing", st[3], 1);
    chk("R5", "short word not stored", st[31:16], 0);
    bus_write(9'd1, 32'd2);
    bus_read(9'd1, st);
    chk("R5", "framing flag cleared", st[3], 0);
    send_word(with_label(8'h11), 33);
    idle(50);
    bus_read(9'd1, st);
    chk("R5", "long word sets framing", st[3], 1);
    chk("R5", "long word not stored", st[31:16], 0);
    bus_write(9'd1, 32'd2);

    w = with_label(8'h11);
    send_word(w, 32); expq.push_back(entry_of(w));
    idle(18);
    send_frame(with_label(8'h11));
    bus_read(9'd1, st);
    chk("R4", "word without gap discarded", st[31:16], 1);
    chk("R4", "missing gap sets framing", st[3], 1);
    drain("R4");
    bus_write(9'd1, 32'd2);

    rx_hi = 1'b1; @(negedge clk); rx_hi = 1'b0;
    idle(50);
    rx_hi = 1'b1; rx_lo = 1'b1; repeat (50) @(negedge clk);
    idle(2);
    w = with_label(8'h11);
    send_frame(w); expq.push_back(entry_of(w));
    bus_read(9'd1, st);
    chk("R1", "glitch and both-high gap tolerated", st[31:16], 1);
    chk("R1", "no framing after glitch", st[3], 0);
    drain("R1");

    for (int k = 0; k <= DEPTH; k++) begin
      w = with_label(8'h11);
      send_frame(w);
      if (k < DEPTH) expq.push_back(entry_of(w));
    end
    bus_read(9'd1, st);
    chk("R10", "full and overflow", st[2:0], 3'b110);
    chk("R10", "level at full", st[31:16], DEPTH);
    bus_write(9'd1, 32'd1);
    bus_read(9'd1, st);
    chk("R10", "overflow cleared, still full", st[2:0], 3'b010);
    drain("R8");
    pop_one();
    bus_read(9'd1, st);
    chk("R8", "pop on empty ignored", st[31:16], 0);

    bus_write(9'd2, 32'd3);
    for (int k = 0; k < 2; k++) begin
      w = with_label(8'h11); send_frame(w); expq.push_back(entry_of(w));
    end
    chk("R11", "irq below threshold", irq, 0);
    w = with_label(8'h11); send_frame(w); expq.push_back(entry_of(w));
    chk("R11", "irq at threshold", irq, 1);
    pop_one(); void'(expq.pop_front());
    chk("R11", "irq after pop", irq, 0);
    bus_write(9'd2, 32'd0);
    chk("R11", "threshold zero disables", irq, 0);
    bus_write(9'd2, 32'd2);
    chk("R11", "irq with threshold two", irq, 1);
    drain("R8");

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule